// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is a small bank of byte-wide configuration registers that a host reaches through two I/O addresses. A write to the index address chooses a register; the next access to the data address reads or writes it. One control register is always reachable. Its map-enable bit decides whether the other registers (the extended set) can be seen at all.

The extended set holds a general configuration register and a parameterised group of spare registers. The two low bits of the general configuration register choose one of four base-address windows. The block drives the resulting base address, which is those two bits placed at the top of a 32-bit word, as a continuous output. The host bus is modelled as single-cycle strobes with an address, a write byte and a combinational read byte.

Top module: `idxcfg_port`

## Requirements
- R1: A write strobe on the index address (default 0x0022) stores the written byte as the selected index and makes it valid for one following data access.
- R2: The control register at index 0xC3 can be read and written through the data address (default 0x0023) whatever the state of its map-enable bit (bit 4).
- R3: While map-enable is 1, the general configuration register (index 0xB8) and the spare registers (indices 0x20 to 0x23) read back the last byte written to them.
- R4: While map-enable is 0, a data read of an extended index returns 0xFF, and a data write to it changes nothing.
- R5: Writing the control register with map-enable 0 hides the extended registers again, and their contents are kept for the next time mapping is enabled.
- R6: Any data-address access makes the index invalid. A data read without a new index write returns 0xFF, and a data write without one changes no register.
- R7: An index that names no register (for example 0x1F, 0x24 or 0x55) reads 0xFF and ignores writes.
- R8: base_addr equals bits [1:0] of the general configuration register shifted left by 30. It shows a new value in the cycle after the write that changes them.
- R9: After reset, map-enable is 0, the index is invalid, the control, general configuration and spare registers are all 0, and base_addr is 0.
- R10: io_rdata is 0xFF in every cycle without a data-address read, which includes reads of the index address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 16 | I/O address of the current cycle |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, valid in the cycle of io_rd |
| base_addr | output | 32 | Selected base-address window |

## Verification
The bench uses the default parameters: 16-bit I/O addresses, the index and data ports at 0x22 and 0x23, four spare registers at 0x20 to 0x23, and map-enable at bit 4 of the control register. With these values every spare index is exercised. So are the unused neighbours just below and just above the spare range, which test both edges of the range decode. All four base windows are reachable from a single byte of general configuration. A pseudo-random phase mixes index writes, data reads and writes, and stray addresses, and runs mapping on and off with the index spent or still valid.

// File: rtl/idxcfg_pkg.sv
package idxcfg_pkg;

   // Which register a data-port access lands on.
   typedef enum logic [1:0] {
      TGT_NONE  = 2'd0,
      TGT_CTRL  = 2'd1,
      TGT_GCFG  = 2'd2,
      TGT_SPARE = 2'd3
   } tgt_e;

   // Width needed to number n items, never below one bit.
   function automatic int sel_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/idxcfg_decode.sv
module idxcfg_decode
   import idxcfg_pkg::*;
#(
   parameter int                ADDR_W     = 16,
   parameter int                DATA_W     = 8,
   parameter logic [ADDR_W-1:0] IDX_PORT   = 16'h0022,
   parameter logic [ADDR_W-1:0] DAT_PORT   = 16'h0023,
   parameter logic [DATA_W-1:0] CTRL_IDX   = 8'hC3,
   parameter logic [DATA_W-1:0] GCFG_IDX   = 8'hB8,
   parameter logic [DATA_W-1:0] SPARE_BASE = 8'h20,
   parameter int                NUM_SPARE  = 4,
   localparam int               SPARE_IW   = sel_width(NUM_SPARE)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   io_addr,
   input  logic                io_wr,
   input  logic                io_rd,
   input  logic [DATA_W-1:0]   io_wdata,
   input  logic                map_en,
   output tgt_e                tgt,
   output logic [SPARE_IW-1:0] spare_sel,
   output logic                dat_wr,
   output logic                dat_rd
);

   localparam logic [DATA_W:0] SPARE_CNT = (DATA_W+1)'(NUM_SPARE);

   logic              idx_hit, dat_hit;
   logic [DATA_W-1:0] idx_q;
   logic              idx_vld_q;
   logic [DATA_W:0]   spare_off;
   logic              in_spare;

   assign idx_hit = (io_addr == IDX_PORT);
   assign dat_hit = (io_addr == DAT_PORT);
   assign dat_wr  = io_wr & dat_hit;
   assign dat_rd  = io_rd & dat_hit;

   // Index latch: armed by an index write, spent by any data access.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q     <= '0;
         idx_vld_q <= 1'b0;
      end else if (io_wr && idx_hit) begin
         idx_q     <= io_wdata;
         idx_vld_q <= 1'b1;
      end else if (dat_wr || dat_rd) begin
         idx_vld_q <= 1'b0;
      end
   end

   // Offset into the spare group; an index below the base wraps past the count.
   assign spare_off = {1'b0, idx_q} - {1'b0, SPARE_BASE};
   assign in_spare  = (spare_off < SPARE_CNT);
   assign spare_sel = spare_off[SPARE_IW-1:0];

   always_comb begin
      tgt = TGT_NONE;
      if (idx_vld_q) begin
         if (idx_q == CTRL_IDX)      tgt = TGT_CTRL;
         else if (map_en) begin
            if (idx_q == GCFG_IDX)   tgt = TGT_GCFG;
            else if (in_spare)       tgt = TGT_SPARE;
         end
      end
   end

   // R1: an index write leaves a valid index equal to the written byte.
   a_r1_index_armed: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && idx_hit) |=> (idx_vld_q && idx_q == $past(io_wdata)));

   // R6: a data access spends the index.
   a_r6_index_spent: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr || dat_rd) |=> !idx_vld_q);

   // R6: with no valid index, no register is targeted.
   a_r6_no_target: assert property (@(posedge clk) disable iff (!rst_n)
      !idx_vld_q |-> (tgt == TGT_NONE));

endmodule

// File: rtl/idxcfg_regs.sv
module idxcfg_regs
   import idxcfg_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter int                NUM_SPARE = 4,
   parameter int                MAPEN_BIT = 4,
   parameter int                GSEL_W    = 2,
   parameter logic [DATA_W-1:0] CTRL_RST  = '0,
   localparam int               SPARE_IW  = sel_width(NUM_SPARE)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  tgt_e                tgt,
   input  logic [SPARE_IW-1:0] spare_sel,
   input  logic                dat_wr,
   input  logic                dat_rd,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   output logic                map_en,
   output logic [GSEL_W-1:0]   gsel
);

   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] gcfg_q;
   logic [DATA_W-1:0] spare_q [NUM_SPARE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         ctrl_q <= CTRL_RST;
      else if (dat_wr && tgt == TGT_CTRL) ctrl_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         gcfg_q <= '0;
      else if (dat_wr && tgt == TGT_GCFG) gcfg_q <= wdata;
   end

   for (genvar i = 0; i < NUM_SPARE; i++) begin : g_spare
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (dat_wr && tgt == TGT_SPARE && spare_sel == SPARE_IW'(i))
            q <= wdata;
      end
      assign spare_q[i] = q;
   end

   always_comb begin
      rdata = '1;
      if (dat_rd) begin
         unique case (tgt)
            TGT_CTRL:  rdata = ctrl_q;
            TGT_GCFG:  rdata = gcfg_q;
            TGT_SPARE: rdata = spare_q[spare_sel];
            default:   rdata = '1;
         endcase
      end
   end

   assign map_en = ctrl_q[MAPEN_BIT];
   assign gsel   = gcfg_q[GSEL_W-1:0];

   // R9: reset leaves the control register with mapping off.
   a_r9_reset_unmapped: assert property (@(posedge clk)
      !rst_n |-> !map_en);

   // R4: the general configuration holds its value unless it is the write target.
   a_r4_gcfg_guarded: assert property (@(posedge clk) disable iff (!rst_n)
      !(dat_wr && tgt == TGT_GCFG) |=> $stable(gcfg_q));

endmodule

// File: rtl/idxcfg_port.sv
module idxcfg_port
   import idxcfg_pkg::*;
#(
   parameter int                ADDR_W     = 16,
   parameter int                DATA_W     = 8,
   parameter logic [ADDR_W-1:0] IDX_PORT   = 16'h0022,
   parameter logic [ADDR_W-1:0] DAT_PORT   = 16'h0023,
   parameter logic [DATA_W-1:0] CTRL_IDX   = 8'hC3,
   parameter int                MAPEN_BIT  = 4,
   parameter logic [DATA_W-1:0] CTRL_RST   = 8'h00,
   parameter logic [DATA_W-1:0] GCFG_IDX   = 8'hB8,
   parameter logic [DATA_W-1:0] SPARE_BASE = 8'h20,
   parameter int                NUM_SPARE  = 4,
   parameter int                GSEL_W     = 2,
   parameter int                BASE_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic [BASE_W-1:0] base_addr
);

   localparam int SPARE_IW = sel_width(NUM_SPARE);
   localparam int SHIFT    = BASE_W - GSEL_W;
   localparam int SPARE_HI = int'(SPARE_BASE) + NUM_SPARE - 1;

   // Elaboration-time parameter checks.
   if (MAPEN_BIT < 0 || MAPEN_BIT >= DATA_W) begin : g_bad_mapen
      $error("map-enable bit outside the data byte");
   end
   if (CTRL_RST[MAPEN_BIT]) begin : g_bad_rst
      $error("control reset value must leave mapping off");
   end
   if (GSEL_W < 1 || GSEL_W > DATA_W || GSEL_W >= BASE_W) begin : g_bad_gsel
      $error("window select width out of range");
   end
   if (NUM_SPARE < 1 || SPARE_HI >= (1 << DATA_W)) begin : g_bad_spare
      $error("spare group does not fit the index space");
   end
   if (IDX_PORT == DAT_PORT || CTRL_IDX == GCFG_IDX) begin : g_bad_alias
      $error("ports or register indices alias");
   end
   if ((int'(CTRL_IDX) >= int'(SPARE_BASE) && int'(CTRL_IDX) <= SPARE_HI) ||
       (int'(GCFG_IDX) >= int'(SPARE_BASE) && int'(GCFG_IDX) <= SPARE_HI)) begin : g_bad_overlap
      $error("spare group overlaps a named register");
   end

   tgt_e                tgt;
   logic [SPARE_IW-1:0] spare_sel;
   logic                dat_wr, dat_rd;
   logic                map_en;
   logic [GSEL_W-1:0]   gsel;

   idxcfg_decode #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .IDX_PORT   (IDX_PORT),
      .DAT_PORT   (DAT_PORT),
      .CTRL_IDX   (CTRL_IDX),
      .GCFG_IDX   (GCFG_IDX),
      .SPARE_BASE (SPARE_BASE),
      .NUM_SPARE  (NUM_SPARE)
   ) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .io_addr   (io_addr),
      .io_wr     (io_wr),
      .io_rd     (io_rd),
      .io_wdata  (io_wdata),
      .map_en    (map_en),
      .tgt       (tgt),
      .spare_sel (spare_sel),
      .dat_wr    (dat_wr),
      .dat_rd    (dat_rd)
   );

   idxcfg_regs #(
      .DATA_W    (DATA_W),
      .NUM_SPARE (NUM_SPARE),
      .MAPEN_BIT (MAPEN_BIT),
      .GSEL_W    (GSEL_W),
      .CTRL_RST  (CTRL_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .tgt       (tgt),
      .spare_sel (spare_sel),
      .dat_wr    (dat_wr),
      .dat_rd    (dat_rd),
      .wdata     (io_wdata),
      .rdata     (io_rdata),
      .map_en    (map_en),
      .gsel      (gsel)
   );

   assign base_addr = {gsel, {SHIFT{1'b0}}};

   // R2: the control register takes a write whatever the mapping state.
   a_r2_ctrl_reach: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && tgt == TGT_CTRL) |=> (map_en == $past(io_wdata[MAPEN_BIT])));

   // R4: an unmapped extended read returns all ones.
   a_r4_hidden_read: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_rd && !map_en && tgt != TGT_CTRL) |-> (io_rdata == '1));

   // R4: an unmapped data write leaves the base window alone.
   a_r4_hidden_write: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && !map_en && tgt != TGT_CTRL) |=> $stable(base_addr));

   // R8: the base window follows the select bits written to the general configuration.
   a_r8_base_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && tgt == TGT_GCFG) |=>
      (base_addr[BASE_W-1 -: GSEL_W] == $past(io_wdata[GSEL_W-1:0])));

   // R10: no data-port read, all-ones read byte.
   a_r10_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_rd && io_addr == DAT_PORT) |-> (io_rdata == '1));

endmodule

// File: tb/idxcfg_port_bench.sv
`timescale 1ns/1ps
module idxcfg_port_bench;

   localparam logic [15:0] P_IDX = 16'h0022;
   localparam logic [15:0] P_DAT = 16'h0023;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic [31:0] base_addr;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;   // 250 MHz

   idxcfg_port u_idxcfg_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .io_addr   (io_addr),
      .io_wr     (io_wr),
      .io_rd     (io_rd),
      .io_wdata  (io_wdata),
      .io_rdata  (io_rdata),
      .base_addr (base_addr)
   );

   // Behavioural reference state.
   logic [7:0] m_ctrl, m_gcfg, m_idx;
   logic [7:0] m_spare [4];
   bit         m_vld;

   function automatic void model_reset();
      m_ctrl = 8'h00; m_gcfg = 8'h00; m_idx = 8'h00; m_vld = 0;
      foreach (m_spare[i]) m_spare[i] = 8'h00;
   endfunction

   function automatic bit mapped();
      return m_ctrl[4];
   endfunction

   // 0 none, 1 control, 2 general config, 3 spare
   function automatic int target();
      if (!m_vld) return 0;
      if (m_idx == 8'hC3) return 1;
      if (!mapped()) return 0;
      if (m_idx == 8'hB8) return 2;
      if (m_idx >= 8'h20 && m_idx <= 8'h23) return 3;
      return 0;
   endfunction

   function automatic string tag_for_access();
      if (!m_vld) return "R6";
      if (m_idx == 8'hC3) return "R2";
      if (m_idx == 8'hB8 || (m_idx >= 8'h20 && m_idx <= 8'h23))
         return mapped() ? "R3" : "R4";
      return "R7";
   endfunction

   function automatic logic [7:0] model_read();
      case (target())
         1: return m_ctrl;
         2: return m_gcfg;
         3: return m_spare[m_idx - 8'h20];
         default: return 8'hFF;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // One bus cycle: drive at the falling edge, compare before the rising edge, update model after.
   task automatic step(input logic [15:0] a, input bit wr, input bit rd, input logic [7:0] d);
      logic [7:0] exp_rd;
      string      tg;
      @(negedge clk);
      io_addr = a; io_wr = wr; io_rd = rd; io_wdata = d;
      #1;
      if (rd && a == P_DAT) begin
         exp_rd = model_read();
         tg     = tag_for_access();
      end else begin
         exp_rd = 8'hFF;
         tg     = "R10";
      end
      check(tg, {24'h0, io_rdata}, {24'h0, exp_rd});
      check("R8", base_addr, {m_gcfg[1:0], 30'h0});
      @(posedge clk);
      if (wr && a == P_IDX) begin
         m_idx = d; m_vld = 1;
      end else if ((wr || rd) && a == P_DAT) begin
         if (wr) begin
            case (target())
               1: m_ctrl = d;
               2: m_gcfg = d;
               3: m_spare[m_idx - 8'h20] = d;
               default: ;
            endcase
         end
         m_vld = 0;
      end
   endtask

   task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
      step(P_IDX, 1, 0, idx);
      step(P_DAT, 1, 0, d);
   endtask

   task automatic rd_reg(input logic [7:0] idx);
      step(P_IDX, 1, 0, idx);
      step(P_DAT, 0, 1, 8'h00);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; io_wr = 0; io_rd = 0;
      model_reset();
      repeat (2) @(negedge clk);
      #1;
      // R9: reset state visible at the ports
      check("R9", base_addr, 32'h0);
      check("R9", {24'h0, io_rdata}, 32'hFF);
      @(negedge clk);
      rst_n = 1;
   endtask

   // Watchdog: a hung run counts as a failure.
   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      logic [7:0]  idx_set [9];
      idx_set = '{8'hC3, 8'hB8, 8'h20, 8'h21, 8'h22, 8'h23, 8'h1F, 8'h24, 8'h55};
      model_reset();
      do_reset();

      // R9: control reads 0, mapping off; general config hidden (R4)
      rd_reg(8'hC3);
      rd_reg(8'hB8);
      // R4: unmapped write ignored
      wr_reg(8'hB8, 8'h03);
      wr_reg(8'h21, 8'h5A);
      // R2: enable mapping (bit 4)
      wr_reg(8'hC3, 8'h10);
      rd_reg(8'hC3);
      // R3/R4: earlier writes did not land
      rd_reg(8'hB8);
      rd_reg(8'h21);
      // R8: each window
      wr_reg(8'hB8, 8'h02);
      step(P_IDX, 0, 0, 8'h00);
      wr_reg(8'hB8, 8'hFF);
      rd_reg(8'hB8);
      wr_reg(8'hB8, 8'h01);
      wr_reg(8'hB8, 8'hA4);
      rd_reg(8'hB8);
      // R3: spares
      for (int i = 0; i < 4; i++) wr_reg(8'h20 + 8'(i), 8'h30 + 8'(i * 17));
      for (int i = 0; i < 4; i++) rd_reg(8'h20 + 8'(i));
      // R6: spent index
      rd_reg(8'h22);
      step(P_DAT, 0, 1, 8'h00);
      wr_reg(8'h23, 8'h77);
      step(P_DAT, 1, 0, 8'hEE);
      rd_reg(8'h23);
      // R7: unused indices around the spare range
      wr_reg(8'h1F, 8'h11);
      wr_reg(8'h24, 8'h22);
      wr_reg(8'h55, 8'h33);
      rd_reg(8'h1F);
      rd_reg(8'h24);
      rd_reg(8'h55);
      for (int i = 0; i < 4; i++) rd_reg(8'h20 + 8'(i));
      // R10: index port read and stray address
      step(P_IDX, 0, 1, 8'h00);
      step(16'h0021, 0, 1, 8'h00);
      // R5: hide, contents kept
      wr_reg(8'hC3, 8'hEF);
      rd_reg(8'hB8);
      rd_reg(8'h20);
      wr_reg(8'hB8, 8'h03);
      wr_reg(8'hC3, 8'h10);
      rd_reg(8'hB8);
      rd_reg(8'h20);

      // Mixed traffic
      lfsr = 16'hACE1;
      for (int n = 0; n < 600; n++) begin
         logic [2:0] op;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         op = lfsr[2:0];
         case (op)
            3'd0, 3'd1: step(P_IDX, 1, 0, idx_set[lfsr[11:8] % 9]);
            3'd2, 3'd3: step(P_DAT, 0, 1, 8'h00);
            3'd4:       step(P_DAT, 1, 0, lfsr[15:8]);
            3'd5:       step(P_DAT, 1, 0, {lfsr[7:5], lfsr[9], lfsr[14:11]});
            3'd6:       step(16'h0021, 1, 0, lfsr[15:8]);
            default:    step(P_IDX, 0, 1, 8'h00);
         endcase
      end

      // R9: reset in mid-run clears everything
      do_reset();
      rd_reg(8'hC3);
      wr_reg(8'hC3, 8'h10);
      rd_reg(8'hB8);
      rd_reg(8'h22);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule